// File: doc/BRIEF.md
# XOR Delta Context Compressor

This block saves the register state of a preempted hardware task in a compact form and later rebuilds a stream that reloads it. It takes two word streams of equal length. The reference stream is the task's original configuration image. The second stream is the image read back from the device, where word k of both streams describes the same device resource. In capture mode the block XORs each pair of words. Bits that never change become zero and only altered state bits remain set. The result is emitted as a token stream in which runs of all-zero difference words are collapsed into counts. Input data must be unencrypted configuration words.

In restore mode the second input carries the saved token stream. The block expands each zero-run token into that many unmodified reference words. It XORs each literal token with the next reference word. The output is therefore the readback image and can be loaded back into the device. Every token is `DATA_W+1` bits wide. Bit `DATA_W` is the tag: 0 means a run of 1 to `RUN_MAX` zero words, with the count in the low `CNT_W = clog2(RUN_MAX+1)` bits and the bits between them zero. 1 means a literal non-zero difference word in bits `DATA_W-1:0`. `DATA_W` must be at least `CNT_W`.

The controller has four states. `ST_RUN` pairs input words or accepts tokens. `ST_LIT` holds a literal that waits behind a run token flushed in the same step. `ST_EXP` counts out a zero run in restore mode. `ST_DRAIN` discards the surplus words of the longer stream after a length error. The transitions are as follows:
- RUN→LIT: a non-zero difference arrives while a run is open.
- LIT→RUN or LIT→DRAIN: the held literal has been emitted.
- RUN→EXP: a run token with a non-zero count is accepted.
- EXP→RUN: the run ends.
- EXP→DRAIN: the run ends and the stream lengths disagree.
- RUN→DRAIN: a length mismatch is detected.
- DRAIN→RUN: the last surplus word has been discarded.

The `mode` input (0 = capture, 1 = restore) must be held constant while a stream is in flight.

Top module: `xor_delta_codec`

## Requirements
- R1: After reset, `out_valid` and `err_len` are 0.
- R2: In capture mode, a word pair with a non-zero XOR produces a literal token (tag 1) whose payload is `ref_data ^ sec_data[DATA_W-1:0]` and is never zero.
- R3: In capture mode, consecutive zero-difference words produce a single run token (tag 0) whose count, in bits `CNT_W-1:0`, equals the number of words it covers (1 to `RUN_MAX`).
- R4: An open run is flushed as soon as its count reaches `RUN_MAX`, and counting restarts from zero on the next word.
- R5: When a non-zero difference arrives while a run is open, the run token is emitted first and the literal token immediately after it.
- R6: A run that is still open when the streams end is flushed as the final token.
- R7: `out_last` is 1 on the final token of a stream and 0 on every other token.
- R8: In restore mode, a run token of count N emits the next N reference words unchanged, and a literal token emits its payload XOR the next reference word. Output bit `DATA_W` is 0, and a capture-then-restore round trip reproduces the readback stream exactly.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds its data and last flag, and no token is lost or repeated under any pattern of input or output stalls.
- R10: In capture mode, if one input ends while the other has more words, `err_len` is raised and the token for that pair carries `out_last`. The surplus words of the longer stream are then accepted and discarded, and `err_len` stays 1 until reset.
- R11: In restore mode, if the reference stream ends before the tokens are exhausted, or the tokens are exhausted before the reference ends, `err_len` is raised and the word produced at that point carries `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = capture, 1 = restore |
| ref_valid | input | 1 | Reference word present |
| ref_ready | output | 1 | Reference word accepted |
| ref_data | input | DATA_W | Original configuration word |
| ref_last | input | 1 | Final reference word |
| sec_valid | input | 1 | Second-stream item present |
| sec_ready | output | 1 | Second-stream item accepted |
| sec_data | input | DATA_W+1 | Readback word (low bits, capture) or token (restore) |
| sec_last | input | 1 | Final second-stream item |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | DATA_W+1 | Token (capture) or restored word with bit DATA_W = 0 (restore) |
| out_last | output | 1 | Final output item |
| err_len | output | 1 | Sticky stream-length mismatch flag |

## Verification
Two functions can fall on the same word.

The first pair is the run-limit flush and the end-of-stream flush. A stream of exactly 255 zero-difference words must yield one run token of 255 with the last flag, not a 255 token followed by an empty one. A stream of 510 zeros and a literal must yield 255, 255 and then the literal.

The second pair is the run flush and the literal. Both are due in the cycle a non-zero word meets an open run. This case is provoked with heavy random output stalls so that the held literal waits several cycles. The behavioural model compares each accepted token in order, and any loss, duplicate or reordering shows up as a mismatch.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LIT   = 2'd1,
        ST_EXP   = 2'd2,
        ST_DRAIN = 2'd3
    } xdc_state_e;

    localparam logic MODE_CAPTURE = 1'b0;
    localparam logic TAG_LITERAL  = 1'b1;
endpackage

// File: rtl/xdc_delta.sv
module xdc_delta #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] d,
    output logic         is_zero
);
    assign d       = a ^ b;
    assign is_zero = (d == '0);
endmodule

// File: rtl/xdc_out_slot.sv
module xdc_out_slot #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         ld_last,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last,
    output logic         free
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_last  <= ld_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/xor_delta_codec.sv
module xor_delta_codec
    import xdc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RUN_MAX = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              ref_valid,
    output logic              ref_ready,
    input  logic [DATA_W-1:0] ref_data,
    input  logic              ref_last,
    input  logic              sec_valid,
    output logic              sec_ready,
    input  logic [DATA_W:0]   sec_data,
    input  logic              sec_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W:0]   out_data,
    output logic              out_last,
    output logic              err_len
);
    localparam int CNT_W = $clog2(RUN_MAX + 1);
    localparam int TOK_W = DATA_W + 1;

    xdc_state_e        state_q, state_n;
    logic [CNT_W-1:0]  run_q, run_n;
    logic [DATA_W-1:0] plit_q, plit_n;
    logic              plast_q, plast_n;
    logic              tlast_q, tlast_n;
    logic              nref_q, nref_n;
    logic              nsec_q, nsec_n;
    logic              err_q, err_n;

    logic [DATA_W-1:0] delta;
    logic              dz;
    logic              free, load, ld_last;
    logic [TOK_W-1:0]  ld_tok;
    logic [CNT_W-1:0]  cnt_inc;
    logic              pair_end, pair_mis;

    xdc_delta #(.W(DATA_W)) u_delta (
        .a       (ref_data),
        .b       (sec_data[DATA_W-1:0]),
        .d       (delta),
        .is_zero (dz)
    );

    xdc_out_slot #(.W(TOK_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_data   (ld_tok),
        .ld_last   (ld_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .free      (free)
    );

    function automatic logic [TOK_W-1:0] run_tok(input logic [CNT_W-1:0] c);
        logic [TOK_W-1:0] t;
        t            = '0;
        t[CNT_W-1:0] = c;
        return t;
    endfunction

    assign cnt_inc  = run_q + 1'b1;
    assign pair_end = ref_last | sec_last;
    assign pair_mis = ref_last ^ sec_last;
    assign err_len  = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            plit_q  <= '0;
            plast_q <= 1'b0;
            tlast_q <= 1'b0;
            nref_q  <= 1'b0;
            nsec_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            run_q   <= run_n;
            plit_q  <= plit_n;
            plast_q <= plast_n;
            tlast_q <= tlast_n;
            nref_q  <= nref_n;
            nsec_q  <= nsec_n;
            err_q   <= err_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        run_n     = run_q;
        plit_n    = plit_q;
        plast_n   = plast_q;
        tlast_n   = tlast_q;
        nref_n    = nref_q;
        nsec_n    = nsec_q;
        err_n     = err_q;
        ref_ready = 1'b0;
        sec_ready = 1'b0;
        load      = 1'b0;
        ld_tok    = '0;
        ld_last   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (mode == MODE_CAPTURE) begin
                    if (ref_valid && sec_valid && free) begin
                        ref_ready = 1'b1;
                        sec_ready = 1'b1;
                        if (pair_mis) begin
                            err_n  = 1'b1;
                            nref_n = sec_last;
                            nsec_n = ref_last;
                        end
                        if (dz) begin
                            if (pair_end) begin
                                load    = 1'b1;
                                ld_tok  = run_tok(cnt_inc);
                                ld_last = 1'b1;
                                run_n   = '0;
                                state_n = pair_mis ? ST_DRAIN : ST_RUN;
                            end else if (cnt_inc == CNT_W'(RUN_MAX)) begin
                                load   = 1'b1;
                                ld_tok = run_tok(cnt_inc);
                                run_n  = '0;
                            end else begin
                                run_n = cnt_inc;
                            end
                        end else if (run_q != '0) begin
                            load    = 1'b1;
                            ld_tok  = run_tok(run_q);
                            plit_n  = delta;
                            plast_n = pair_end;
                            run_n   = '0;
                            state_n = ST_LIT;
                        end else begin
                            load    = 1'b1;
                            ld_tok  = {TAG_LITERAL, delta};
                            ld_last = pair_end;
                            state_n = pair_mis ? ST_DRAIN : ST_RUN;
                        end
                    end
                end else if (sec_valid) begin
                    if (sec_data[DATA_W] == TAG_LITERAL) begin
                        if (ref_valid && free) begin
                            ref_ready = 1'b1;
                            sec_ready = 1'b1;
                            load      = 1'b1;
                            ld_tok    = {1'b0, delta};
                            ld_last   = pair_end;
                            if (pair_mis) begin
                                err_n  = 1'b1;
                                nref_n = sec_last;
                                nsec_n = ref_last;
                            end
                            state_n = pair_mis ? ST_DRAIN : ST_RUN;
                        end
                    end else begin
                        sec_ready = 1'b1;
                        if (sec_data[CNT_W-1:0] != '0) begin
                            run_n   = sec_data[CNT_W-1:0];
                            tlast_n = sec_last;
                            state_n = ST_EXP;
                        end
                    end
                end
            end
            ST_LIT: begin
                if (free) begin
                    load    = 1'b1;
                    ld_tok  = {TAG_LITERAL, plit_q};
                    ld_last = plast_q;
                    state_n = (nref_q || nsec_q) ? ST_DRAIN : ST_RUN;
                end
            end
            ST_EXP: begin
                if (ref_valid && free) begin
                    ref_ready = 1'b1;
                    load      = 1'b1;
                    ld_tok    = {1'b0, ref_data};
                    run_n     = run_q - 1'b1;
                    if (run_q == CNT_W'(1)) begin
                        ld_last = tlast_q | ref_last;
                        state_n = ST_RUN;
                        if (tlast_q != ref_last) begin
                            err_n   = 1'b1;
                            nref_n  = tlast_q;
                            nsec_n  = ref_last;
                            state_n = ST_DRAIN;
                        end
                    end else if (ref_last) begin
                        ld_last = 1'b1;
                        err_n   = 1'b1;
                        run_n   = '0;
                        nsec_n  = !tlast_q;
                        state_n = tlast_q ? ST_RUN : ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                ref_ready = nref_q;
                sec_ready = nsec_q;
                if (nref_q && ref_valid && ref_last) nref_n = 1'b0;
                if (nsec_q && sec_valid && sec_last) nsec_n = 1'b0;
                if (!nref_n && !nsec_n) state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end
endmodule

// File: rtl/xdc_checks.sv
module xdc_checks #(
    parameter int DATA_W  = 16,
    parameter int RUN_MAX = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W:0]   out_data,
    input logic              out_last,
    input logic              err_len
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |=> err_len);

    assert_run_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !mode && !out_data[DATA_W] |->
            (out_data[DATA_W-1:0] != '0) && (out_data[DATA_W-1:0] <= DATA_W'(RUN_MAX)));

    assert_lit_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !mode && out_data[DATA_W] |-> out_data[DATA_W-1:0] != '0);

    assert_restore_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode |-> !out_data[DATA_W]);
endmodule

bind xor_delta_codec xdc_checks #(.DATA_W(DATA_W), .RUN_MAX(RUN_MAX)) u_xdc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .err_len   (err_len)
);

// File: tb/test_xor_delta_codec.sv
`timescale 1ns/1ps
module test_xor_delta_codec;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          ref_valid = 1'b0, ref_last = 1'b0;
    logic [DW-1:0] ref_data = '0;
    logic          sec_valid = 1'b0, sec_last = 1'b0;
    logic [DW:0]   sec_data = '0;
    logic          out_ready = 1'b0;
    logic          ref_ready, sec_ready, out_valid, out_last, err_len;
    logic [DW:0]   out_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [DW-1:0] refq[$];
    logic [DW-1:0] rbq[$];
    logic [DW:0]   secq[$];
    logic [DW+1:0] expq[$];
    logic [DW:0]   capq[$];

    always #4 clk = ~clk;

    xor_delta_codec #(.DATA_W(DW), .RUN_MAX(255)) i_xor_delta_codec (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_data(ref_data), .ref_last(ref_last),
        .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_data(sec_data), .sec_last(sec_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .err_len(err_len)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_valid = 0; sec_valid = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(err_len == 1'b0, "R1 err_len after reset", err_len, 0);
        @(posedge clk); #1;
    endtask

    // behavioural capture model
    task automatic build_capture();
        int n, run;
        logic [DW-1:0] d;
        expq.delete();
        n = (refq.size() < rbq.size()) ? refq.size() : rbq.size();
        run = 0;
        for (int k = 0; k < n; k++) begin
            bit e;
            e = (k == n - 1);
            d = refq[k] ^ rbq[k];
            if (d == '0) begin
                run++;
                if (e) begin expq.push_back({1'b1, 1'b0, DW'(run)}); run = 0; end
                else if (run == 255) begin expq.push_back({1'b0, 1'b0, DW'(run)}); run = 0; end
            end else begin
                if (run > 0) begin expq.push_back({1'b0, 1'b0, DW'(run)}); run = 0; end
                expq.push_back({e, 1'b1, d});
            end
        end
        secq.delete();
        foreach (rbq[k]) secq.push_back({1'b0, rbq[k]});
    endtask

    task automatic build_restore();
        expq.delete();
        foreach (rbq[k]) expq.push_back({k == rbq.size() - 1, 1'b0, rbq[k]});
        secq = capq;
    endtask

    task automatic run_stream(input logic md, input int stall_pct, input string req);
        int ri = 0, si = 0, got = 0, cyc = 0;
        bit ar, as;
        mode = md;
        capq.delete();
        forever begin
            ref_valid = (ri < refq.size()) && (($urandom % 100) >= 20);
            ref_data  = (ri < refq.size()) ? refq[ri] : '0;
            ref_last  = (ri == refq.size() - 1);
            sec_valid = (si < secq.size()) && (($urandom % 100) >= 20);
            sec_data  = (si < secq.size()) ? secq[si] : '0;
            sec_last  = (si == secq.size() - 1);
            out_ready = (($urandom % 100) >= stall_pct);
            @(negedge clk);
            ar = ref_valid && ref_ready;
            as = sec_valid && sec_ready;
            if (out_valid && out_ready) begin
                if (got >= expq.size())
                    chk(1'b0, {req, " extra token"}, {out_last, out_data}, 0);
                else
                    chk({out_last, out_data} == expq[got], req, {out_last, out_data}, expq[got]);
                capq.push_back(out_data);
                got++;
            end
            @(posedge clk); #1;
            ri += int'(ar);
            si += int'(as);
            cyc++;
            if (ri == refq.size() && si == secq.size() && got >= expq.size() && !out_valid) break;
            if (cyc > 20000) begin
                chk(1'b0, {req, " stream stuck"}, cyc, 20000);
                break;
            end
        end
        ref_valid = 0; sec_valid = 0;
        chk(got == expq.size(), {req, " R9 token count"}, got, expq.size());
    endtask

    task automatic fill_pair(input int n, input int kind);
        refq.delete(); rbq.delete();
        for (int k = 0; k < n; k++) begin
            logic [DW-1:0] r, m;
            r = DW'($urandom);
            m = '0;
            if (kind == 1 && (k % 7 == 3 || k == n - 1)) m = DW'($urandom) | 16'h0001;
            if (kind == 2 && k == n - 1) m = 16'h8001;
            if (kind == 3 && k == 0) m = 16'h0100;
            refq.push_back(r);
            rbq.push_back(r ^ m);
        end
    endtask

    task automatic cap_and_restore(input int n, input int kind, input int stall, input string req);
        fill_pair(n, kind);
        build_capture();
        run_stream(1'b0, stall, req);
        chk(err_len == 1'b0, {req, " R10 no false err"}, err_len, 0);
        build_restore();
        run_stream(1'b1, stall, "R8 round trip");
    endtask

    initial begin
        do_reset();
        // R2 R5 R7 mixed differences with runs in between
        cap_and_restore(24, 1, 30, "R2 R5 R7 mixed");
        // R4 R6 300 zeros: 255 then 45 last
        cap_and_restore(300, 0, 10, "R4 R6 300 zeros");
        // R4 R6 exactly 255 zeros: single token 255 last
        cap_and_restore(255, 0, 10, "R4 R6 255 zeros");
        chk(expq.size() == 255, "R4 restore length", expq.size(), 255);
        // R4 R5 510 zeros then literal: 255,255,lit
        cap_and_restore(511, 2, 20, "R4 R5 510 zeros+lit");
        // R9 heavy stall, literal first then run to end (R3 R6)
        cap_and_restore(40, 3, 75, "R3 R6 R9 stall");

        // R11 restore: run of 5 against 3 reference words
        mode = 1'b1;
        refq.delete();
        for (int k = 0; k < 3; k++) refq.push_back(DW'(16'h1110 + k));
        secq.delete(); secq.push_back({1'b0, 16'd5});
        expq.delete();
        for (int k = 0; k < 3; k++) expq.push_back({k == 2, 1'b0, refq[k]});
        run_stream(1'b1, 20, "R11 short ref");
        chk(err_len == 1'b1, "R11 err_len", err_len, 1);

        do_reset();
        // R10 capture: ref 4, readback 6
        fill_pair(6, 0);
        rbq[1] = rbq[1] ^ 16'h0040;
        void'(refq.pop_back()); void'(refq.pop_back());
        build_capture();
        run_stream(1'b0, 20, "R10 ref short");
        chk(err_len == 1'b1, "R10 err_len raised", err_len, 1);
        // R10 capture: ref 6, readback 3
        fill_pair(6, 1);
        void'(rbq.pop_back()); void'(rbq.pop_back()); void'(rbq.pop_back());
        build_capture();
        run_stream(1'b0, 20, "R10 readback short");
        // R10 sticky and later stream still correct
        fill_pair(10, 1);
        build_capture();
        run_stream(1'b0, 0, "R10 after error");
        chk(err_len == 1'b1, "R10 err_len sticky", err_len, 1);

        do_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule